// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns one high-level request (word program, sector erase, whole-device erase, unlock-bypass entry or exit, return to read mode, secure-area entry or exit) into the series of write cycles that a parallel NOR flash expects on its address, data and write-enable pins. The caller gives an operation code, a target address, a data word and a width mode. The width mode picks the pair of unlock addresses that the command prefix uses. The block then issues one write cycle after another. Each cycle has a setup clock, a strobe low for a parameter-set number of clocks, and a hold clock.

The sequencer tracks whether the device is in unlock-bypass mode. While that mode is active, a program request shrinks to two cycles. The caller sees `req_ready` low while a sequence runs. A one-clock `done` pulse marks the end of the last cycle. Polling the flash for completion is left to other logic.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `bus_we_n` is 1, `req_ready` is 1, `done` is 0, and `bus_addr` and `bus_data` are 0.
- R2: Each bus cycle has three parts. First comes one clock with `bus_we_n` high. Then `bus_we_n` is low for exactly STROBE_CLKS clocks. Then comes one clock with `bus_we_n` high. `bus_addr` and `bus_data` hold the same value from the setup clock through the hold clock.
- R3: The two unlock addresses depend on `req_mode`, given as first/second. Mode 0 (byte device) uses 0x555/0x2AA. Mode 1 (16-bit device on a byte bus) uses 0xAAA/0x555. Mode 2 (16-bit device) uses 0xAAA/0x554. Mode 3 (32-bit device) uses 0x1555/0xAAA.
- R4: Op 0 (program) outside bypass issues four cycles: 0xAA at the first unlock address, 0x55 at the second, 0xA0 at the first, then `req_data` at `req_addr`. Command bytes sit in the low byte of `bus_data` and the upper bits are zero.
- R5: Op 1 (sector erase) issues six cycles: 0xAA@U1, 0x55@U2, 0x80@U1, 0xAA@U1, 0x55@U2, then 0x30 at `req_addr`. Op 2 (whole-device erase) issues the same first five cycles, then 0x10@U1.
- R6: Op 3 (bypass entry) issues 0xAA@U1, 0x55@U2, 0x20@U1 and sets bypass mode. In bypass mode, op 0 issues only two cycles: 0xA0 at address 0, then `req_data` at `req_addr`.
- R7: Op 4 (bypass exit) issues 0x90 then 0x00, both at address 0, and clears bypass mode. After that, program again takes four cycles. No other op changes bypass mode.
- R8: Op 5 (return to read mode) issues a single cycle, 0xF0 at address 0.
- R9: Op 6 (secure-area entry) issues 0xAA@U1, 0x55@U2, 0x88@U1. Op 7 (secure-area exit) issues 0xAA@U1, 0x55@U2, 0x90@U1, 0x00@U1.
- R10: A request is taken on a clock where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until `done`. Requests presented while it is 0 are ignored and add no bus cycles.
- R11: `done` is high for exactly one clock. That clock is the one that follows the hold clock of the last cycle, and `req_ready` is 1 in the same clock. `done` is first seen L*(STROBE_CLKS+2) clocks after the accepting edge, where L is the number of cycles in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_mode | input | 2 | Device width mode (0..3) |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Data word for program |
| bus_addr | output | AW | Flash address bus |
| bus_data | output | DW | Flash data bus (write direction) |
| bus_we_n | output | 1 | Flash write enable, active low |
| done | output | 1 | Last cycle of the sequence issued |

## Verification
The bypass state is the hardest condition to reach, because it is held inside the block and has no output of its own. The only way to see it is through how long a later program sequence is. The stimulus therefore runs a fixed chain of requests for each width mode. The chain issues exit and entry at points where they have no effect, enters bypass, runs every operation while bypass is set, and then leaves it. A program request issued after each of these steps shows whether the mode flag was set or cleared correctly. One request is also held valid through the busy window with a different operation, to show that nothing is accepted while `req_ready` is low.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_PROG        = 3'd0,
    OP_SECT_ERASE  = 3'd1,
    OP_CHIP_ERASE  = 3'd2,
    OP_BYP_ENTER   = 3'd3,
    OP_BYP_EXIT    = 3'd4,
    OP_READ_MODE   = 3'd5,
    OP_SEC_ENTER   = 3'd6,
    OP_SEC_EXIT    = 3'd7
  } nor_op_e;

  typedef enum logic [1:0] {
    ADR_KEY1   = 2'd0,
    ADR_KEY2   = 2'd1,
    ADR_TARGET = 2'd2,
    ADR_BASE   = 2'd3
  } adr_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    adr_sel_e    asel;
    logic        use_word;
    logic [7:0]  cmd;
  } step_t;

  localparam int STEP_W = 3;

  function automatic step_t mk(adr_sel_e a, logic w, logic [7:0] c);
    step_t s;
    s.asel = a;
    s.use_word = w;
    s.cmd = c;
    return s;
  endfunction

  // Unlock address for a width mode; second selects the other key.
  function automatic logic [15:0] key_addr(logic [1:0] mode, logic second);
    logic [15:0] a;
    case (mode)
      2'd0:    a = second ? 16'h02AA : 16'h0555;
      2'd1:    a = second ? 16'h0555 : 16'h0AAA;
      2'd2:    a = second ? 16'h0554 : 16'h0AAA;
      default: a = second ? 16'h0AAA : 16'h1555;
    endcase
    return a;
  endfunction

  // Number of bus cycles in a sequence.
  function automatic logic [STEP_W-1:0] seq_len(nor_op_e op, logic byp);
    logic [STEP_W-1:0] n;
    case (op)
      OP_PROG:                     n = byp ? 3'd2 : 3'd4;
      OP_SECT_ERASE, OP_CHIP_ERASE: n = 3'd6;
      OP_BYP_ENTER, OP_SEC_ENTER:  n = 3'd3;
      OP_BYP_EXIT:                 n = 3'd2;
      OP_READ_MODE:                n = 3'd1;
      default:                     n = 3'd4;
    endcase
    return n;
  endfunction

  // Descriptor of cycle idx of a sequence.
  function automatic step_t seq_step(nor_op_e op, logic byp, logic [STEP_W-1:0] idx);
    step_t s;
    s = mk(ADR_BASE, 1'b0, 8'hF0);
    if (idx == 3'd0) s = mk(ADR_KEY1, 1'b0, 8'hAA);
    if (idx == 3'd1) s = mk(ADR_KEY2, 1'b0, 8'h55);
    case (op)
      OP_PROG: begin
        if (byp) begin
          s = (idx == 3'd0) ? mk(ADR_BASE, 1'b0, 8'hA0) : mk(ADR_TARGET, 1'b1, 8'h00);
        end else if (idx == 3'd2) begin
          s = mk(ADR_KEY1, 1'b0, 8'hA0);
        end else if (idx == 3'd3) begin
          s = mk(ADR_TARGET, 1'b1, 8'h00);
        end
      end
      OP_SECT_ERASE, OP_CHIP_ERASE: begin
        case (idx)
          3'd2: s = mk(ADR_KEY1, 1'b0, 8'h80);
          3'd3: s = mk(ADR_KEY1, 1'b0, 8'hAA);
          3'd4: s = mk(ADR_KEY2, 1'b0, 8'h55);
          3'd5: s = (op == OP_SECT_ERASE) ? mk(ADR_TARGET, 1'b0, 8'h30)
                                          : mk(ADR_KEY1, 1'b0, 8'h10);
          default: ;
        endcase
      end
      OP_BYP_ENTER: if (idx == 3'd2) s = mk(ADR_KEY1, 1'b0, 8'h20);
      OP_BYP_EXIT:  s = (idx == 3'd0) ? mk(ADR_BASE, 1'b0, 8'h90) : mk(ADR_BASE, 1'b0, 8'h00);
      OP_READ_MODE: s = mk(ADR_BASE, 1'b0, 8'hF0);
      OP_SEC_ENTER: if (idx == 3'd2) s = mk(ADR_KEY1, 1'b0, 8'h88);
      default: begin
        if (idx == 3'd2) s = mk(ADR_KEY1, 1'b0, 8'h90);
        if (idx == 3'd3) s = mk(ADR_KEY1, 1'b0, 8'h00);
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nor_step_rom.sv
module nor_step_rom
  import nor_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  nor_op_e           op,
  input  logic [1:0]        mode,
  input  logic              byp,
  input  logic [STEP_W-1:0] idx,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [DW-1:0]     tgt_data,
  output logic [AW-1:0]     cyc_addr,
  output logic [DW-1:0]     cyc_data,
  output logic              cyc_last
);
  step_t             st;
  logic [STEP_W-1:0] len;

  assign st  = seq_step(op, byp, idx);
  assign len = seq_len(op, byp);

  always_comb begin
    case (st.asel)
      ADR_KEY1:   cyc_addr = AW'(key_addr(mode, 1'b0));
      ADR_KEY2:   cyc_addr = AW'(key_addr(mode, 1'b1));
      ADR_TARGET: cyc_addr = tgt_addr;
      default:    cyc_addr = '0;
    endcase
    cyc_data = st.use_word ? tgt_data : DW'(st.cmd);
  end

  assign cyc_last = (idx == len - 3'd1);
endmodule

// File: rtl/nor_strobe_timer.sv
module nor_strobe_timer
  import nor_seq_pkg::*;
#(
  parameter int STROBE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic we_n,
  output logic slot_end
);
  localparam int CW = $clog2(STROBE_CLKS + 1);

  phase_e        ph, ph_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    ph_n  = ph;
    cnt_n = cnt;
    case (ph)
      PH_IDLE:  if (start) ph_n = PH_SETUP;
      PH_SETUP: begin
        ph_n  = PH_STROBE;
        cnt_n = CW'(1);
      end
      PH_STROBE: begin
        if (cnt == CW'(STROBE_CLKS)) ph_n = PH_HOLD;
        else cnt_n = cnt + CW'(1);
      end
      default:  ph_n = start ? PH_SETUP : PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      we_n <= 1'b1;
    end else begin
      ph   <= ph_n;
      cnt  <= cnt_n;
      we_n <= (ph_n != PH_STROBE);
    end
  end

  assign slot_end = (ph == PH_HOLD);
endmodule

// File: rtl/nor_bypass_flag.sv
module nor_bypass_flag
  import nor_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    finish,
  input  nor_op_e op,
  output logic    byp
);
  always_ff @(posedge clk) begin
    if (!rst_n) byp <= 1'b0;
    else if (finish) begin
      if (op == OP_BYP_ENTER) byp <= 1'b1;
      else if (op == OP_BYP_EXIT) byp <= 1'b0;
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int STROBE_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          bus_we_n,
  output logic          done
);
  logic              busy_q, last_q, byp;
  nor_op_e           op_q;
  logic [1:0]        mode_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic [STEP_W-1:0] idx_q;

  // Named internal events
  logic              accept, slot_end, advance, finish, start;
  nor_op_e           sel_op;
  logic [1:0]        sel_mode;
  logic [AW-1:0]     sel_addr, rom_addr;
  logic [DW-1:0]     sel_data, rom_data;
  logic [STEP_W-1:0] sel_idx;
  logic              rom_last;

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;
  assign advance   = busy_q && slot_end && !last_q;
  assign finish    = busy_q && slot_end && last_q;
  assign start     = accept || advance;

  assign sel_op   = accept ? nor_op_e'(req_op) : op_q;
  assign sel_mode = accept ? req_mode : mode_q;
  assign sel_addr = accept ? req_addr : addr_q;
  assign sel_data = accept ? req_data : data_q;
  assign sel_idx  = accept ? '0 : idx_q + 3'd1;

  nor_step_rom #(.AW(AW), .DW(DW)) u_rom (
    .op(sel_op), .mode(sel_mode), .byp(byp), .idx(sel_idx),
    .tgt_addr(sel_addr), .tgt_data(sel_data),
    .cyc_addr(rom_addr), .cyc_data(rom_data), .cyc_last(rom_last)
  );

  nor_strobe_timer #(.STROBE_CLKS(STROBE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .we_n(bus_we_n), .slot_end(slot_end)
  );

  nor_bypass_flag u_byp (
    .clk(clk), .rst_n(rst_n), .finish(finish), .op(op_q), .byp(byp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      last_q   <= 1'b0;
      op_q     <= OP_PROG;
      mode_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      idx_q    <= '0;
      bus_addr <= '0;
      bus_data <= '0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= sel_op;
        mode_q <= req_mode;
        addr_q <= req_addr;
        data_q <= req_data;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
      if (start) begin
        idx_q    <= sel_idx;
        last_q   <= rom_last;
        bus_addr <= rom_addr;
        bus_data <= rom_data;
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int STROBE_CLKS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data,
  input logic          bus_we_n,
  input logic          done,
  input logic          accept,
  input logic          finish
);
  int low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || bus_we_n) low_cnt <= 0;
    else low_cnt <= low_cnt + 1;
  end

  assert_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_data)));
  assert_strobe_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && !$past(bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_data)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_data)));
  assert_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> (low_cnt == STROBE_CLKS));
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_idle_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_we_n);
  assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_finish_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done);
  assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> req_ready);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW), .STROBE_CLKS(STROBE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .bus_addr(bus_addr), .bus_data(bus_data), .bus_we_n(bus_we_n),
  .done(done), .accept(accept), .finish(finish)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int SC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [1:0] req_mode = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic bus_we_n, done;

  nor_cmd_seq #(.AW(AW), .DW(DW), .STROBE_CLKS(SC)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bus monitor: logs each strobe and checks R2 framing.
  logic [AW-1:0] mon_a [0:1023];
  logic [DW-1:0] mon_d [0:1023];
  int mon_n = 0, mon_checks = 0, mon_fails = 0, low_len = 0;
  logic p_we = 1'b1;
  logic [AW-1:0] p_a = '0;
  logic [DW-1:0] p_d = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_we_n && p_we) begin
        mon_checks++;
        if (bus_addr !== p_a || bus_data !== p_d) begin
          mon_fails++;
          $display("FAIL R2 setup: addr/data %h/%h expected %h/%h", bus_addr, bus_data, p_a, p_d);
        end
        if (mon_n < 1024) begin
          mon_a[mon_n] = bus_addr;
          mon_d[mon_n] = bus_data;
        end
        mon_n++;
        low_len = 1;
      end else if (!bus_we_n) begin
        low_len++;
      end
      if (bus_we_n && !p_we) begin
        mon_checks++;
        if (low_len != SC || bus_addr !== p_a || bus_data !== p_d) begin
          mon_fails++;
          $display("FAIL R2 strobe/hold: width %0d addr %h data %h expected width %0d addr %h data %h",
                   low_len, bus_addr, bus_data, SC, p_a, p_d);
        end
      end
    end
    p_we = bus_we_n;
    p_a  = bus_addr;
    p_d  = bus_data;
  end

  int checks = 0, fails = 0;
  logic [AW-1:0] exp_a [0:7];
  logic [DW-1:0] exp_d [0:7];
  int exp_n;
  logic model_byp = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic build(input int op, input int mode, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] k1, k2;
    exp_n = 0;
    // R3 unlock address table
    case (mode)
      0: begin k1 = 24'h555;  k2 = 24'h2AA; end
      1: begin k1 = 24'hAAA;  k2 = 24'h555; end
      2: begin k1 = 24'hAAA;  k2 = 24'h554; end
      default: begin k1 = 24'h1555; k2 = 24'hAAA; end
    endcase
    case (op)
      0: if (model_byp) begin push(0, 16'hA0); push(a, d); end            // R6
         else begin push(k1, 16'hAA); push(k2, 16'h55); push(k1, 16'hA0); push(a, d); end // R4
      1, 2: begin                                                            // R5
        push(k1, 16'hAA); push(k2, 16'h55); push(k1, 16'h80);
        push(k1, 16'hAA); push(k2, 16'h55);
        if (op == 1) push(a, 16'h30); else push(k1, 16'h10);
      end
      3: begin push(k1, 16'hAA); push(k2, 16'h55); push(k1, 16'h20); end   // R6
      4: begin push(0, 16'h90); push(0, 16'h00); end                         // R7
      5: push(0, 16'hF0);                                                    // R8
      6: begin push(k1, 16'hAA); push(k2, 16'h55); push(k1, 16'h88); end   // R9
      default: begin push(k1, 16'hAA); push(k2, 16'h55); push(k1, 16'h90); push(k1, 16'h00); end
    endcase
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R4/R6";
      1, 2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Issue one request; hold_busy keeps valid high with another op for a few clocks.
  task automatic issue(input int op, input int mode, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit hold_busy);
    int start_n, acc, lat, wd;
    string rq;
    rq = req_of(op);
    build(op, mode, a, d);
    @(negedge clk);
    wd = 0;
    while (!req_ready && wd < 1000) begin @(negedge clk); wd++; end
    start_n = mon_n;
    req_op = 3'(op); req_mode = 2'(mode); req_addr = a; req_data = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    if (hold_busy) begin
      req_op = 3'd5; req_addr = 24'hFFFFFF; req_data = 16'hFFFF;
      for (int i = 0; i < 3; i++) begin
        chk(req_ready == 1'b0 && done == 1'b0, "R10 ready low while busy", req_ready, 0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    wd = 0;
    while (!done && wd < 1000) begin @(negedge clk); wd++; end
    lat = cyc - acc;
    chk(done == 1'b1 && req_ready == 1'b1, "R11 done with ready", {done, req_ready}, 2'b11);
    chk(lat == exp_n * (SC + 2), "R11 latency", lat, exp_n * (SC + 2));
    @(negedge clk);
    chk(done == 1'b0, "R11 done one clock", done, 0);
    chk(mon_n - start_n == exp_n, {rq, " cycle count"}, mon_n - start_n, exp_n);
    for (int i = 0; i < exp_n && i < mon_n - start_n; i++) begin
      chk(mon_a[start_n+i] == exp_a[i], {rq, "/R3 address"}, mon_a[start_n+i], exp_a[i]);
      chk(mon_d[start_n+i] == exp_d[i], {rq, " data"}, mon_d[start_n+i], exp_d[i]);
    end
    if (op == 3) model_byp = 1'b1;
    if (op == 4) model_byp = 1'b0;
  endtask

  function automatic int op_at(input int k);
    case (k)
      0: return 0;  1: return 1;  2: return 2;  3: return 5;
      4: return 6;  5: return 7;  6: return 4;  7: return 3;
      8: return 0;  9: return 1;  10: return 2; 11: return 5;
      12: return 6; 13: return 7; 14: return 3; 15: return 0;
      16: return 4; default: return 0;
    endcase
  endfunction

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_we_n == 1'b1 && req_ready == 1'b1 && done == 1'b0, "R1 control after reset",
        {bus_we_n, req_ready, done}, 3'b110);
    chk(bus_addr == '0 && bus_data == '0, "R1 bus after reset", {bus_addr, bus_data}, 0);
    // Sweep all modes through a chain that walks bypass state in and out
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 18; k++) begin
        issue(op_at(k), m, AW'(24'h012340 + m * 24'h1000 + k * 24'h11),
              DW'(16'hC3A5 ^ (k * 16'h0101) ^ m), 1'b0);
      end
    end
    // R10: request held through busy window is ignored
    issue(2, 1, 24'h00ABCD, 16'h1234, 1'b1);
    n0 = mon_n;
    repeat (3 * (SC + 2)) @(negedge clk);
    chk(mon_n == n0, "R10 no cycles after ignored request", mon_n - n0, 0);
    issue(0, 3, 24'hFEDCBA, 16'hBEEF, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end
endmodule